// File: doc/BRIEF.md
# ECC Error Capture and Status Registers

This block sits beside a memory datapath and turns correctable (single-bit) and uncorrectable (multi-bit) ECC error events into state that software can read. Each event arrives with the page number of the failing access, which is physical address bits 31:12. It also carries the memory row that an external row decoder has already resolved. The block holds that state in three registers on a simple register bus. Reads are combinational. Writes take effect on the clock edge.

The page register stores one 4 KB-aligned location and two sticky flags, one per error kind. Once either flag is set the stored page is frozen, so software always sees the location of the first logged error. The stored page changes again only after software has cleared both flags by writing ones to them. The status register tracks each error kind on its own: a sticky flag, plus the row of the first error of that kind since the flag was last cleared. A command register enables a single system-error output for each error kind. That output stays high while any enabled status flag is set.

Top module: `errlog_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and `serr_o` is low.
- R2: An event on either channel, arriving while both page-register flags are clear, loads its page into bits 31:12 of the page register (select 0). Bits 11:2 of that register always read zero.
- R3: In the page register, bit 0 is set by every single-bit event and bit 1 by every multi-bit event, whether or not the page is frozen.
- R4: Writing 1 to bit 0 or bit 1 of the page register clears that flag. Writing 0 leaves it unchanged. Writes never alter bits 31:12. An event arriving in the same cycle as a clear of its own flag wins, and the flag stays set.
- R5: While either page-register flag is set, bits 31:12 of the page register do not change, whatever events arrive.
- R6: When both kinds of event arrive in the same cycle with the page unfrozen, both flags are set and the multi-bit channel's page is the one stored.
- R7: The status register (select 1) reads as follows. Bit 0 is the single-bit flag. Bits 3:1 hold the row of the first single-bit error. Bit 4 is the multi-bit flag. Bits 7:5 hold the row of the first multi-bit error. Bits 31:8 read zero. A row is loaded only by an event arriving while that kind's flag is clear.
- R8: Writing 1 to status bit 0 clears the single-bit flag, and writing 1 to bit 4 clears the multi-bit flag. Writing 0 has no effect. An event in the same cycle as a clear keeps its flag set.
- R9: The command register (select 2) stores bit 0 (enable for single-bit errors) and bit 1 (enable for multi-bit errors). All other bits read zero.
- R10: `serr_o` is high exactly when (command bit 0 and the status single-bit flag) or (command bit 1 and the status multi-bit flag). The output follows a flag or enable change on the clock edge that changes it.
- R11: Select value 3 reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_evt_i | input | 1 | Single-bit error event, one cycle per event |
| sb_page_i | input | 20 | Address bits 31:12 of the single-bit error |
| sb_row_i | input | 3 | Decoded memory row of the single-bit error |
| mb_evt_i | input | 1 | Multi-bit error event |
| mb_page_i | input | 20 | Address bits 31:12 of the multi-bit error |
| mb_row_i | input | 3 | Decoded memory row of the multi-bit error |
| bus_sel_i | input | 2 | Register select: 0 page, 1 status, 2 command, 3 none |
| bus_we_i | input | 1 | Write strobe for the selected register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register |
| serr_o | output | 1 | System-error output |

## Verification
The block is first driven with lone single-bit events, then with lone multi-bit events, and then with both kinds in the same cycle. These runs separate the page capture of each channel from the priority given to the multi-bit channel. Events are then sent while flags are already set, with different pages and rows each time. This shows whether the page freeze and the first-row capture hold independently, and whether the sticky flags still set. Writes of zeros, of ones, and of a clear in the same cycle as an event show whether write-one-to-clear is honoured and whether the event wins over the clear. Every enable combination is set against every flag state to check the system-error output. A final run of pseudo-random events and writes is compared with the reference model on every cycle.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int ROW_W    = 3;
    localparam int DATA_W   = 32;
    localparam int NKIND    = 2;
    localparam int KIND_SB  = 0;
    localparam int KIND_MB  = 1;

    // status layout: per kind one flag followed by its row field
    localparam int ST_SB_FLAG = 0;
    localparam int ST_MB_FLAG = ROW_W + 1;
    localparam int ST_USED    = 2 * (ROW_W + 1);

    typedef enum logic [1:0] {
        SEL_PAGE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             hit;
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
    } err_evt_t;

    typedef struct packed {
        logic             flag;
        logic [ROW_W-1:0] row;
    } kind_state_t;

    function automatic logic [DATA_W-1:0] pack_status(kind_state_t sb, kind_state_t mb);
        logic [DATA_W-1:0] v;
        v = '0;
        v[ST_SB_FLAG]                    = sb.flag;
        v[ST_SB_FLAG+1 +: ROW_W]         = sb.row;
        v[ST_MB_FLAG]                    = mb.flag;
        v[ST_MB_FLAG+1 +: ROW_W]         = mb.row;
        return v;
    endfunction

endpackage

// File: rtl/errlog_kind_trk.sv
module errlog_kind_trk
    import errlog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  err_evt_t    evt_i,
    input  logic        clr_i,
    output kind_state_t state_o
);

    kind_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (evt_i.hit && !st_q.flag)
                st_q.row <= evt_i.row;
            st_q.flag <= (st_q.flag && !clr_i) || evt_i.hit;
        end
    end

    assign state_o = st_q;

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.flag && !clr_i) |=> st_q.flag);

    // R8
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.hit |=> st_q.flag);

    // R7
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.flag |=> $stable(st_q.row));

endmodule

// File: rtl/errlog_page_cap.sv
module errlog_page_cap
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  err_evt_t          sb_evt_i,
    input  err_evt_t          mb_evt_i,
    input  logic              clr_sb_i,
    input  logic              clr_mb_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              sb_flag_o,
    output logic              mb_flag_o
);

    logic [PAGE_W-1:0] page_q;
    logic              sbf_q, mbf_q;
    logic              frozen, load;

    assign frozen = sbf_q || mbf_q;
    assign load   = (sb_evt_i.hit || mb_evt_i.hit) && !frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            sbf_q  <= 1'b0;
            mbf_q  <= 1'b0;
        end else begin
            if (load)
                page_q <= mb_evt_i.hit ? mb_evt_i.page : sb_evt_i.page;
            sbf_q <= (sbf_q && !clr_sb_i) || sb_evt_i.hit;
            mbf_q <= (mbf_q && !clr_mb_i) || mb_evt_i.hit;
        end
    end

    assign page_o    = page_q;
    assign sb_flag_o = sbf_q;
    assign mb_flag_o = mbf_q;

    // R5
    page_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (sbf_q || mbf_q) |=> $stable(page_q));

    // R6
    mb_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (!sbf_q && !mbf_q && mb_evt_i.hit) |=> (page_q == $past(mb_evt_i.page)));

    // R3
    flags_set_chk: assert property (@(posedge clk) disable iff (rst)
        (sb_evt_i.hit && mb_evt_i.hit) |=> (sbf_q && mbf_q));

endmodule

// File: rtl/errlog_top.sv
module errlog_top
    import errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sb_evt_i,
    input  logic [PAGE_W-1:0] sb_page_i,
    input  logic [ROW_W-1:0]  sb_row_i,
    input  logic              mb_evt_i,
    input  logic [PAGE_W-1:0] mb_page_i,
    input  logic [ROW_W-1:0]  mb_row_i,
    input  logic [1:0]        bus_sel_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              serr_o
);

    reg_sel_e          sel;
    err_evt_t          evt    [NKIND];
    logic              st_clr [NKIND];
    kind_state_t       st     [NKIND];
    logic [PAGE_W-1:0] page;
    logic              pg_sb, pg_mb;
    logic [NKIND-1:0]  cmd_q;
    logic              wr_page, wr_stat, wr_cmd;
    logic              unused_wdata;

    assign sel     = reg_sel_e'(bus_sel_i);
    assign wr_page = bus_we_i && (sel == SEL_PAGE);
    assign wr_stat = bus_we_i && (sel == SEL_STAT);
    assign wr_cmd  = bus_we_i && (sel == SEL_CMD);
    assign unused_wdata = ^{bus_wdata_i[DATA_W-1:ST_USED]};

    assign evt[KIND_SB] = '{hit: sb_evt_i, page: sb_page_i, row: sb_row_i};
    assign evt[KIND_MB] = '{hit: mb_evt_i, page: mb_page_i, row: mb_row_i};
    assign st_clr[KIND_SB] = wr_stat && bus_wdata_i[ST_SB_FLAG];
    assign st_clr[KIND_MB] = wr_stat && bus_wdata_i[ST_MB_FLAG];

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        errlog_kind_trk u_trk (
            .clk     (clk),
            .rst     (rst),
            .evt_i   (evt[k]),
            .clr_i   (st_clr[k]),
            .state_o (st[k])
        );
    end

    errlog_page_cap u_page (
        .clk       (clk),
        .rst       (rst),
        .sb_evt_i  (evt[KIND_SB]),
        .mb_evt_i  (evt[KIND_MB]),
        .clr_sb_i  (wr_page && bus_wdata_i[0]),
        .clr_mb_i  (wr_page && bus_wdata_i[1]),
        .page_o    (page),
        .sb_flag_o (pg_sb),
        .mb_flag_o (pg_mb)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (wr_cmd)
            cmd_q <= bus_wdata_i[NKIND-1:0];
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            SEL_PAGE: bus_rdata_o = {page, {(PAGE_LSB-2){1'b0}}, pg_mb, pg_sb};
            SEL_STAT: bus_rdata_o = pack_status(st[KIND_SB], st[KIND_MB]);
            SEL_CMD:  bus_rdata_o = {{(DATA_W-NKIND){1'b0}}, cmd_q};
            SEL_NONE: bus_rdata_o = '0;
        endcase
    end

    assign serr_o = (cmd_q[KIND_SB] && st[KIND_SB].flag) ||
                    (cmd_q[KIND_MB] && st[KIND_MB].flag);

    // R10
    serr_no_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!st[KIND_SB].flag && !st[KIND_MB].flag) |-> !serr_o);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd |=> $stable(cmd_q));

    // R11
    none_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata_o == '0));

endmodule

// File: tb/test_errlog_top.sv
module test_errlog_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sb_evt = 0, mb_evt = 0;
    logic [19:0] sb_page = '0, mb_page = '0;
    logic [2:0]  sb_row = '0, mb_row = '0;
    logic [1:0]  sel = '0;
    logic        we = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        serr;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference state
    logic [19:0] m_page = '0;
    logic        m_psb = 0, m_pmb = 0, m_ssb = 0, m_smb = 0;
    logic [2:0]  m_sbrow = '0, m_mbrow = '0;
    logic [1:0]  m_cmd = '0;

    always #2.5 clk = ~clk;

    errlog_top i_errlog_top (
        .clk(clk), .rst(rst),
        .sb_evt_i(sb_evt), .sb_page_i(sb_page), .sb_row_i(sb_row),
        .mb_evt_i(mb_evt), .mb_page_i(mb_page), .mb_row_i(mb_row),
        .bus_sel_i(sel), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .serr_o(serr)
    );

    always @(posedge clk) begin
        logic wp, ws, wc, frz;
        if (rst) begin
            m_page = '0; m_psb = 0; m_pmb = 0; m_ssb = 0; m_smb = 0;
            m_sbrow = '0; m_mbrow = '0; m_cmd = '0;
        end else begin
            wp  = we && sel == 2'd0;
            ws  = we && sel == 2'd1;
            wc  = we && sel == 2'd2;
            frz = m_psb || m_pmb;
            if ((sb_evt || mb_evt) && !frz) m_page = mb_evt ? mb_page : sb_page;
            m_psb = (m_psb && !(wp && wdata[0])) || sb_evt;
            m_pmb = (m_pmb && !(wp && wdata[1])) || mb_evt;
            if (sb_evt && !m_ssb) m_sbrow = sb_row;
            if (mb_evt && !m_smb) m_mbrow = mb_row;
            m_ssb = (m_ssb && !(ws && wdata[0])) || sb_evt;
            m_smb = (m_smb && !(ws && wdata[4])) || mb_evt;
            if (wc) m_cmd = wdata[1:0];
        end
    end

    function automatic logic [31:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0:    return {m_page, 10'b0, m_pmb, m_psb};
            2'd1:    return {24'b0, m_mbrow, m_smb, m_sbrow, m_ssb};
            2'd2:    return {30'b0, m_cmd};
            default: return 32'b0;
        endcase
    endfunction

    task automatic check_now();
        logic es;
        es = (m_cmd[0] && m_ssb) || (m_cmd[1] && m_smb);
        checks++;
        if (rdata !== exp_rd(sel)) begin
            fails++;
            $display("FAIL %s: sel %0d rdata %h expected %h", tag, sel, rdata, exp_rd(sel));
        end
        checks++;
        if (serr !== es) begin
            fails++;
            $display("FAIL %s: serr %b expected %b", tag, serr, es);
        end
    endtask

    // one clock: inputs already driven; sample at the falling edge, then idle inputs
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_now();
        sb_evt = 0; mb_evt = 0; we = 0;
    endtask

    task automatic rd(input logic [1:0] s);
        sel = s; we = 0;
        #0.5;
        check_now();
    endtask

    task automatic read_all();
        for (int s = 0; s < 4; s++) rd(2'(s));
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        sel = s; we = 1; wdata = d;
        tick();
    endtask

    task automatic ev(input logic sb, input logic [19:0] sp, input logic [2:0] sr,
                      input logic mb, input logic [19:0] mp, input logic [2:0] mr);
        sb_evt = sb; sb_page = sp; sb_row = sr;
        mb_evt = mb; mb_page = mp; mb_row = mr;
        tick();
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R1"; read_all();

        tag = "R2"; ev(1, 20'h12345, 3'd5, 0, 20'h0, 3'd0); read_all();
        tag = "R5"; ev(0, 20'h0, 3'd0, 1, 20'hABCDE, 3'd6); read_all();
        tag = "R3"; ev(1, 20'h55555, 3'd1, 0, 20'h0, 3'd0); rd(0);
        tag = "R4"; wr(0, 32'hFFFF_F000); rd(0);
        wr(0, 32'h0000_0001); rd(0);
        wr(0, 32'hFFFF_FFFF); rd(0);
        tag = "R7"; rd(1);
        tag = "R8"; wr(1, 32'h0); rd(1);
        wr(1, 32'h11); rd(1);

        tag = "R6"; ev(1, 20'h11111, 3'd2, 1, 20'h22222, 3'd3); read_all();
        tag = "R4"; sel = 0; we = 1; wdata = 32'h1; sb_evt = 1; sb_page = 20'h77777; tick(); rd(0);
        wr(0, 32'h3); rd(0);
        tag = "R8"; sel = 1; we = 1; wdata = 32'h1; sb_evt = 1; sb_row = 3'd7; tick(); rd(1);
        tag = "R7"; ev(1, 20'h1, 3'd4, 1, 20'h2, 3'd0); rd(1);
        wr(1, 32'h11); ev(0, 20'h0, 3'd0, 1, 20'h3, 3'd4); rd(1);

        tag = "R9"; wr(2, 32'hFFFF_FFFF); rd(2);
        wr(2, 32'h0); rd(2);
        tag = "R10";
        for (int c = 0; c < 4; c++) begin
            wr(1, 32'h11); wr(2, 32'(c)); rd(2);
            ev(1, 20'h9, 3'd1, 0, 20'h0, 3'd0); rd(1);
            ev(0, 20'h0, 3'd0, 1, 20'h8, 3'd2); rd(1);
            wr(1, 32'h01); rd(1);
            wr(1, 32'h10); rd(1);
        end
        tag = "R11"; wr(3, 32'hFFFF_FFFF); read_all();

        tag = "R2"; lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sb_evt = lfsr[0] & lfsr[5]; mb_evt = lfsr[1] & lfsr[6] & lfsr[9];
            sb_page = lfsr[31:12]; mb_page = lfsr[27:8];
            sb_row = lfsr[4:2]; mb_row = lfsr[13:11];
            sel = lfsr[15:14]; we = lfsr[16] & lfsr[17];
            wdata = {lfsr[7:0], lfsr[31:8]};
            tick();
            for (int s = 0; s < 4; s++) rd(2'(s));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule